// File: doc/BRIEF.md
# Cascadable Carrier Summation Output Stage

This stage adds one locally generated carrier sample to a cascade sample arriving from an identical stage upstream. It registers the result as an 18-bit wideband word. Several stages are chained to build a composite multi-carrier signal. The first stage has its cascade input tied to zero, and the last stage drives a DAC.

On intermediate stages, clip detection is off. The sum then wraps at 18 bits, and the top bit acts as a guard bit, so running sums may go past the 17-bit full scale without losing anything. On the final stage, clip detection is normally on. The sum then saturates at the 17-bit full scale, and the top bit becomes a clip flag that fires for overflow in either direction.

The final stage can also convert its output to offset binary. The conversion follows a tap selection that names which output bit is wired to the DAC MSB. For the top bit or the next bit down, the selected sign bit is inverted. For the lower taps, a compensation constant is added.

Top module: `carrier_sum_stage`

## Requirements
- R1: While rst_ni is low, data_o is 0 and valid_o is 0.
- R2: valid_o equals valid_i delayed by one clock. data_o loads only on clocks where valid_i is high and holds its value otherwise.
- R3: carrier_i is a 16-bit two's-complement value that is sign-extended to 18 bits and added to the 18-bit two's-complement casc_i. With clip_en_i low and no conversion, data_o is that sum modulo 2^18, and bit 17 carries sum data (for example 0x0F000 + 0x7FFF gives 0x16FFF).
- R4: With clip_en_i high, a sum above 65535 produces data_o[16:0] = 0x0FFFF and data_o[17] = 1.
- R5: With clip_en_i high, a sum below -65536 produces data_o[16:0] = 0x10000 and data_o[17] = 1.
- R6: With clip_en_i high, a sum from -65536 to 65535 inclusive produces data_o[16:0] equal to the low 17 bits of the sum, and data_o[17] = 0.
- R7: With offbin_en_i high and tap_sel_i = 0 (DAC MSB on bit 17), bit 17 of the word from R3 to R6 is inverted.
- R8: With offbin_en_i high and tap_sel_i = t in 1..6 (DAC MSB on bit b = 17 - t), the value 2^17 - 2^b is added modulo 2^17 to bits 16:0, and bit 17 is left unchanged. The constants for t = 1 to 6 are 0x10000, 0x18000, 0x1C000, 0x1E000, 0x1F000 and 0x1F800.
- R9: With offbin_en_i low, or with tap_sel_i = 7, no conversion is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| casc_i | input | 18 | Cascade sample from the upstream stage, two's complement |
| carrier_i | input | 16 | Local carrier sample, two's complement |
| clip_en_i | input | 1 | Saturate and use bit 17 as the clip flag |
| offbin_en_i | input | 1 | Enable offset-binary conversion |
| tap_sel_i | input | 3 | DAC MSB tap: 0 selects bit 17, t selects bit 17-t, 7 selects none |
| data_o | output | 18 | Registered wideband output |
| valid_o | output | 1 | Output strobe |

## Verification
Every result, including valid_o, comes out of a single register. It is therefore due at the first rising edge after the inputs are applied. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge, so each check reads exactly the word built from the inputs it just applied. Hold behaviour is checked across two idle clocks after new inputs have been applied with valid_i low. The reset value is checked both at start-up and during a mid-run reset.

// File: rtl/csum_pkg.sv
package csum_pkg;
  // Offset-binary compensation added to a dat_w-bit word when the DAC MSB sits tap places below the top bit
  function automatic logic [31:0] tap_comp(input int dat_w, input int tap);
    return (32'd1 << dat_w) - (32'd1 << (dat_w - tap));
  endfunction
endpackage

// File: rtl/csum_add_sat.sv
module csum_add_sat #(
  parameter int OUT_W = 18,
  parameter int CAR_W = 16
) (
  input  logic [OUT_W-1:0] casc_i,
  input  logic [CAR_W-1:0] carrier_i,
  input  logic             clip_en_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int SUM_W = OUT_W + 1;
  localparam int DAT_W = OUT_W - 1;
  localparam int TOP_W = SUM_W - DAT_W + 1;

  logic [SUM_W-1:0] sum;
  logic [TOP_W-1:0] top;
  logic             fits;

  assign sum  = {casc_i[OUT_W-1], casc_i} + {{(SUM_W-CAR_W){carrier_i[CAR_W-1]}}, carrier_i};
  assign top  = sum[SUM_W-1:DAT_W-1];
  // Sum fits a 17-bit signed word when all upper bits agree
  assign fits = (top == '0) || (top == '1);

  always_comb begin
    if (!clip_en_i) begin
      word_o = sum[OUT_W-1:0];
    end else if (fits) begin
      word_o = {1'b0, sum[DAT_W-1:0]};
    end else if (!sum[SUM_W-1]) begin
      word_o = {1'b1, 1'b0, {(DAT_W-1){1'b1}}};
    end else begin
      word_o = {1'b1, 1'b1, {(DAT_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/csum_fmt.sv
module csum_fmt #(
  parameter int OUT_W       = 18,
  parameter int MIN_TAP_BIT = 11,
  parameter int TAP_W       = 3
) (
  input  logic [OUT_W-1:0] word_i,
  input  logic             offbin_en_i,
  input  logic [TAP_W-1:0] tap_sel_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int DAT_W    = OUT_W - 1;
  localparam int NUM_TAPS = OUT_W - MIN_TAP_BIT;
  localparam int TAB_N    = 2 ** TAP_W;

  logic [DAT_W-1:0] comp_tab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_comp
    if (g >= 1 && g < NUM_TAPS) begin : g_used
      assign comp_tab[g] = DAT_W'(csum_pkg::tap_comp(DAT_W, g));
    end else begin : g_none
      assign comp_tab[g] = '0;
    end
  end

  always_comb begin
    word_o = word_i;
    if (offbin_en_i) begin
      if (tap_sel_i == '0) begin
        word_o[OUT_W-1] = ~word_i[OUT_W-1];
      end else if (int'(tap_sel_i) < NUM_TAPS) begin
        word_o[DAT_W-1:0] = word_i[DAT_W-1:0] + comp_tab[tap_sel_i];
      end
    end
  end
endmodule

// File: rtl/csum_out_reg.sv
module csum_out_reg #(
  parameter int OUT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OUT_W-1:0] word_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= word_i;
    end
  end
endmodule

// File: rtl/carrier_sum_stage.sv
module carrier_sum_stage #(
  parameter int OUT_W       = 18,
  parameter int CAR_W       = 16,
  parameter int MIN_TAP_BIT = 11,
  parameter int TAP_W       = $clog2(OUT_W - MIN_TAP_BIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OUT_W-1:0] casc_i,
  input  logic [CAR_W-1:0] carrier_i,
  input  logic             clip_en_i,
  input  logic             offbin_en_i,
  input  logic [TAP_W-1:0] tap_sel_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] sat_word;
  logic [OUT_W-1:0] fmt_word;

  csum_add_sat #(.OUT_W(OUT_W), .CAR_W(CAR_W)) u_add_sat (
    .casc_i    (casc_i),
    .carrier_i (carrier_i),
    .clip_en_i (clip_en_i),
    .word_o    (sat_word)
  );

  csum_fmt #(.OUT_W(OUT_W), .MIN_TAP_BIT(MIN_TAP_BIT), .TAP_W(TAP_W)) u_fmt (
    .word_i      (sat_word),
    .offbin_en_i (offbin_en_i),
    .tap_sel_i   (tap_sel_i),
    .word_o      (fmt_word)
  );

  csum_out_reg #(.OUT_W(OUT_W)) u_out_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .word_i  (fmt_word),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/csum_chk.sv
module csum_chk #(
  parameter int OUT_W = 18,
  parameter int CAR_W = 16,
  parameter int TAP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OUT_W-1:0] casc_i,
  input logic [CAR_W-1:0] carrier_i,
  input logic             clip_en_i,
  input logic             offbin_en_i,
  input logic [TAP_W-1:0] tap_sel_i,
  input logic [OUT_W-1:0] data_o,
  input logic             valid_o
);
  localparam int POS_LIM = 2 ** (OUT_W - 2) - 1;
  localparam int NEG_LIM = -(2 ** (OUT_W - 2));
  localparam logic [OUT_W-1:0] POS_WORD = {2'b10, {(OUT_W-2){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_WORD = {2'b11, {(OUT_W-2){1'b0}}};

  logic signed [OUT_W:0] ref_sum;
  logic                  plain_clip;
  assign ref_sum    = $signed({casc_i[OUT_W-1], casc_i}) + $signed({{(OUT_W+1-CAR_W){carrier_i[CAR_W-1]}}, carrier_i});
  assign plain_clip = valid_i && clip_en_i && !offbin_en_i;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o);
  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(data_o));
  // R3
  wrap_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clip_en_i && !offbin_en_i |=> data_o == $past(ref_sum[OUT_W-1:0]));
  // R4
  pos_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_clip && (ref_sum > POS_LIM) |=> data_o == POS_WORD);
  // R5
  neg_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_clip && (ref_sum < NEG_LIM) |=> data_o == NEG_WORD);
  // R6
  no_clip_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_clip && (ref_sum <= POS_LIM) && (ref_sum >= NEG_LIM) |=> !data_o[OUT_W-1]);
endmodule

bind carrier_sum_stage csum_chk #(.OUT_W(OUT_W), .CAR_W(CAR_W), .TAP_W(TAP_W)) u_csum_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .casc_i      (casc_i),
  .carrier_i   (carrier_i),
  .clip_en_i   (clip_en_i),
  .offbin_en_i (offbin_en_i),
  .tap_sel_i   (tap_sel_i),
  .data_o      (data_o),
  .valid_o     (valid_o)
);

// File: tb/carrier_sum_stage_bench.sv
module carrier_sum_stage_bench;
  typedef struct packed {
    logic [17:0] casc;
    logic [15:0] car;
    logic        clip;
    logic        ob;
    logic [2:0]  tap;
    logic [17:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{18'h00000, 16'h1234, 1'b0, 1'b0, 3'd0, 18'h01234, "R3"},
    '{18'h3FFFF, 16'hFFFF, 1'b0, 1'b0, 3'd0, 18'h3FFFE, "R3"},
    '{18'h0F000, 16'h7FFF, 1'b0, 1'b0, 3'd0, 18'h16FFF, "R3"},
    '{18'h1FFFF, 16'h0001, 1'b0, 1'b0, 3'd0, 18'h20000, "R3"},
    '{18'h0F000, 16'h7FFF, 1'b1, 1'b0, 3'd0, 18'h2FFFF, "R4"},
    '{18'h0FFFF, 16'h0001, 1'b1, 1'b0, 3'd0, 18'h2FFFF, "R4"},
    '{18'h30000, 16'h8000, 1'b1, 1'b0, 3'd0, 18'h30000, "R5"},
    '{18'h30000, 16'hFFFF, 1'b1, 1'b0, 3'd0, 18'h30000, "R5"},
    '{18'h01000, 16'h0100, 1'b1, 1'b0, 3'd0, 18'h01100, "R6"},
    '{18'h3F000, 16'h0000, 1'b1, 1'b0, 3'd0, 18'h1F000, "R6"},
    '{18'h0FFFF, 16'h0000, 1'b1, 1'b0, 3'd0, 18'h0FFFF, "R6"},
    '{18'h30000, 16'h0000, 1'b1, 1'b0, 3'd0, 18'h10000, "R6"},
    '{18'h00000, 16'h0000, 1'b0, 1'b1, 3'd0, 18'h20000, "R7"},
    '{18'h3FFFF, 16'h0000, 1'b0, 1'b1, 3'd0, 18'h1FFFF, "R7"},
    '{18'h00000, 16'h0000, 1'b1, 1'b1, 3'd1, 18'h10000, "R8"},
    '{18'h0F000, 16'h7FFF, 1'b1, 1'b1, 3'd1, 18'h3FFFF, "R8"},
    '{18'h00000, 16'h0000, 1'b1, 1'b1, 3'd2, 18'h18000, "R8"},
    '{18'h00100, 16'h0000, 1'b1, 1'b1, 3'd2, 18'h18100, "R8"},
    '{18'h04000, 16'h0000, 1'b0, 1'b1, 3'd3, 18'h00000, "R8"},
    '{18'h00001, 16'h0000, 1'b1, 1'b1, 3'd4, 18'h1E001, "R8"},
    '{18'h00010, 16'h0000, 1'b1, 1'b1, 3'd6, 18'h1F810, "R8"},
    '{18'h3FFFF, 16'h0000, 1'b1, 1'b1, 3'd6, 18'h1F7FF, "R8"},
    '{18'h00123, 16'h0000, 1'b1, 1'b1, 3'd7, 18'h00123, "R9"},
    '{18'h00123, 16'h0000, 1'b1, 1'b0, 3'd5, 18'h00123, "R9"},
    '{18'h00001, 16'h0000, 1'b1, 1'b1, 3'd5, 18'h1F001, "R8"}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [17:0] casc_i = '0;
  logic [15:0] carrier_i = '0;
  logic        clip_en_i = 1'b0;
  logic        offbin_en_i = 1'b0;
  logic [2:0]  tap_sel_i = '0;
  logic [17:0] data_o;
  logic        valid_o;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  carrier_sum_stage u_carrier_sum_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .casc_i      (casc_i),
    .carrier_i   (carrier_i),
    .clip_en_i   (clip_en_i),
    .offbin_en_i (offbin_en_i),
    .tap_sel_i   (tap_sel_i),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%05h expected 0x%05h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    @(negedge clk_i);
    casc_i      = v.casc;
    carrier_i   = v.car;
    clip_en_i   = v.clip;
    offbin_en_i = v.ob;
    tap_sel_i   = v.tap;
    valid_i     = vld;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check("R1", data_o, 18'h0);
    check("R1", {17'h0, valid_o}, 18'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(posedge clk_i);
      #1;
      check(string'(VECS[i].tag), data_o, VECS[i].exp);
      // R2 strobe follows with one cycle latency
      check("R2", {17'h0, valid_o}, 18'h1);
    end

    // R2: idle cycles hold the last word and drop the strobe
    drive('{18'h01111, 16'h2222, 1'b0, 1'b0, 3'd0, 18'h0, "R2"}, 1'b0);
    @(posedge clk_i);
    #1;
    check("R2", {17'h0, valid_o}, 18'h0);
    check("R2", data_o, 18'h1F001);
    drive('{18'h3ABCD, 16'h8000, 1'b1, 1'b1, 3'd2, 18'h0, "R2"}, 1'b0);
    @(posedge clk_i);
    #1;
    check("R2", data_o, 18'h1F001);

    // R2: a single-cycle strobe gives exactly one output strobe
    drive('{18'h00005, 16'h0003, 1'b0, 1'b0, 3'd0, 18'h0, "R2"}, 1'b1);
    @(posedge clk_i);
    #1;
    check("R2", {17'h0, valid_o}, 18'h1);
    check("R3", data_o, 18'h00008);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    check("R2", {17'h0, valid_o}, 18'h0);
    check("R2", data_o, 18'h00008);

    // R1 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", data_o, 18'h0);
    check("R1", {17'h0, valid_o}, 18'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule